// File: doc/BRIEF.md
# Framebuffer Pixel Unpacker with Colour Lookup

This block takes one framebuffer pixel word per beat and turns it into a 24-bit red/green/blue value for a display panel. A static format code picks how the word is read. The supported layouts are 16-bit 5-6-5, 16-bit 1-5-5-5 with an ignored alpha bit, 24-bit packed 8-8-8, 32-bit unpacked 8-8-8, 32-bit 8-8-8 with an 8-bit alpha, and 8-bit indexed colour. Narrow channels are widened to 8 bits by copying their top bits into the vacant low bits.

Indexed pixels are looked up in a 256-entry table of 24-bit colours. Software-style logic loads that table through a small two-step port. It first loads a 24-bit data holding register, then issues a write command that carries the 8-bit entry number. Each format code carries a channel-order bit. A panel-wide swap input is XORed with that bit to decide whether red and blue trade places at the output.

Pixels stream in and out with valid/ready handshakes. Every format takes the same two-register latency, so pixel order is always kept.

Top module: `pix_unpack`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `m_valid` is 0, and the lookup data holding register reads as 0.
- R2: `cfg_fmt[3:1]` selects the layout class: 0 = 5-6-5, 1 = 1-5-5-5, 2 = 24-bit packed, 3 = 32-bit unpacked, 4 = 32-bit with alpha, 5 = indexed, 6 and 7 behave as 3. `cfg_fmt[0]` is the order bit: 0 means the upper colour field is red, 1 means it is blue.
- R3: In class 0, the upper field is `s_data[15:11]`, green is `s_data[10:5]` and the lower field is `s_data[4:0]`. A 5-bit value v becomes {v, v[4:2]}, and a 6-bit value g becomes {g, g[5:4]}.
- R4: In class 1, the upper field is `s_data[14:10]`, green is `s_data[9:5]` and the lower field is `s_data[4:0]`, each widened as a 5-bit value. `s_data[15]` has no effect on the output.
- R5: In classes 2, 3 and 4, the upper field is `s_data[23:16]`, green is `s_data[15:8]` and the lower field is `s_data[7:0]`. `s_data[31:24]` has no effect on the output.
- R6: `m_rgb` is {red[23:16], green[15:8], blue[7:0]}. Red and blue are exchanged exactly when `cfg_fmt[0]` XOR `cfg_panel_swap` is 1, and this applies to every class, indexed included.
- R7: In class 5, `s_data[7:0]` selects a table entry, and the stored 24-bit value (as {upper, green, lower}) is the output. `s_data[31:8]` is ignored.
- R8: A cycle with `lut_load` high stores `lut_data` in the holding register. A cycle with `lut_wr` high copies the holding register into entry `lut_idx`. `lut_load` alone changes no entry. Writes take effect whether or not the stream is stalled.
- R9: A pixel accepted at clock edge k appears on `m_rgb` with `m_valid` high after edge k+1, provided `m_ready` is high at edge k+1. Pixels leave in the order they entered, whatever their formats.
- R10: `s_ready` equals `m_ready`. While `m_ready` is low, `m_valid` and `m_rgb` keep their values and no input is taken.
- R11: A beat with `s_valid` low, advancing with `m_ready` high, reaches the output as `m_valid` low.
- R12: When a table write and the lookup read of the same entry fall on the same clock edge, the pixel gets the entry's old value, and later pixels get the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fmt | input | 4 | Format code: class in [3:1], order bit in [0] |
| cfg_panel_swap | input | 1 | Panel-wide red/blue exchange strap |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high |
| s_data | input | 32 | Input pixel word, right-aligned |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream ready; low stalls the pipeline |
| m_rgb | output | 24 | Output colour {red, green, blue} |
| lut_load | input | 1 | Load `lut_data` into the holding register |
| lut_data | input | 24 | Colour value for the table |
| lut_wr | input | 1 | Write the holding register into entry `lut_idx` |
| lut_idx | input | 8 | Table entry to write |

## Verification
Two functions can land on the same clock edge: a table write command and the lookup read of an indexed pixel that addresses the same entry. The bench provokes this by placing an indexed pixel into the first stage and raising `lut_wr` for that entry in the next cycle. It then judges that the pixel carries the old colour while the next pixel with that index carries the new one. A second overlap is also tested: a table write issued while the output is stalled. Here the held output must stay unchanged and the new colour must appear on the next pixel.

// File: rtl/pix_unpack_pkg.sv
// Package: shared types for the pixel unpacker.
// Assumes 8-bit output channels; layout classes are encoded in 3 bits.
package pix_unpack_pkg;

    localparam int CH_W  = 8;
    localparam int RGB_W = 3 * CH_W;

    // Layout class carried in the upper bits of the format code
    typedef enum logic [2:0] {
        CLS_565   = 3'd0,
        CLS_1555  = 3'd1,
        CLS_P888  = 3'd2,
        CLS_U888  = 3'd3,
        CLS_A888  = 3'd4,
        CLS_INDEX = 3'd5
    } fmt_class_e;

    // Colour in field order: hi = upper field, lo = lower field
    typedef struct packed {
        logic [CH_W-1:0] hi;
        logic [CH_W-1:0] mid;
        logic [CH_W-1:0] lo;
    } rgb_t;

endpackage

// File: rtl/pix_field_decode.sv
// Module: pix_field_decode
// Splits one aligned pixel word into three 8-bit channels for the
// true-colour classes and extracts the table index for indexed class.
// Assumes the word is right-aligned; purely combinational.
module pix_field_decode
    import pix_unpack_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic [DATA_W-1:0] word,
    input  logic [2:0]        cls,
    output rgb_t              px,
    output logic              is_idx,
    output logic [IDX_W-1:0]  idx
);

    // Widen a 5-bit channel by repeating its top bits
    function automatic logic [CH_W-1:0] widen5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    // Widen a 6-bit channel by repeating its top bits
    function automatic logic [CH_W-1:0] widen6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction

    // Field extraction per layout class
    always_comb begin
        px     = '0;
        is_idx = 1'b0;
        unique case (fmt_class_e'(cls))
            CLS_565: begin
                px.hi  = widen5(word[15:11]);
                px.mid = widen6(word[10:5]);
                px.lo  = widen5(word[4:0]);
            end
            CLS_1555: begin
                px.hi  = widen5(word[14:10]);
                px.mid = widen5(word[9:5]);
                px.lo  = widen5(word[4:0]);
            end
            CLS_INDEX: begin
                is_idx = 1'b1;
            end
            default: begin
                px.hi  = word[23:16];
                px.mid = word[15:8];
                px.lo  = word[7:0];
            end
        endcase
    end

    assign idx = word[IDX_W-1:0];

endmodule

// File: rtl/pix_clut.sv
// Module: pix_clut
// Colour lookup table with a holding register for write data and a
// registered read port. Assumes a read and a write on the same edge
// to one entry return the value held before that edge.
module pix_clut #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 24,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [WIDTH-1:0] ld_data,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] hold_q;
    logic [WIDTH-1:0] mem [DEPTH];

    // Holding register for the next table write
    always_ff @(posedge clk) begin
        if (!rst_n)  hold_q <= '0;
        else if (ld) hold_q <= ld_data;
    end

    // Table write from the holding register
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= hold_q;
    end

    // Registered read, frozen when the pipeline stalls
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/pix_rb_order.sv
// Module: pix_rb_order
// Maps a field-ordered colour onto the {red, green, blue} output,
// exchanging the outer fields when asked. Purely combinational.
module pix_rb_order
    import pix_unpack_pkg::*;
(
    input  rgb_t             px,
    input  logic             swap,
    output logic [RGB_W-1:0] rgb
);

    // Outer-field exchange
    always_comb begin
        if (swap) rgb = {px.lo, px.mid, px.hi};
        else      rgb = {px.hi, px.mid, px.lo};
    end

endmodule

// File: rtl/pix_unpack.sv
// Module: pix_unpack
// Two-stage pixel unpacker. Stage 1 registers the decoded fields and
// table index; stage 2 registers the table read beside the true-colour
// path, so all classes share one latency. Assumes cfg inputs are static
// per stream; the whole pipeline advances only when m_ready is high.
module pix_unpack
    import pix_unpack_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LUT_DEPTH = 256,
    localparam int IDX_W    = $clog2(LUT_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cfg_fmt,
    input  logic              cfg_panel_swap,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [RGB_W-1:0]  m_rgb,
    input  logic              lut_load,
    input  logic [RGB_W-1:0]  lut_data,
    input  logic              lut_wr,
    input  logic [IDX_W-1:0]  lut_idx
);

    logic             adv;
    rgb_t             dec_px;
    logic             dec_idx_en;
    logic [IDX_W-1:0] dec_idx;

    logic             v1_q, ind1_q, swap1_q;
    rgb_t             px1_q;
    logic [IDX_W-1:0] idx1_q;

    logic             v2_q, ind2_q, swap2_q;
    rgb_t             px2_q;
    logic [RGB_W-1:0] lut_rd;
    rgb_t             sel_px;

    assign adv     = m_ready;
    assign s_ready = m_ready;

    pix_field_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec (
        .word   (s_data),
        .cls    (cfg_fmt[3:1]),
        .px     (dec_px),
        .is_idx (dec_idx_en),
        .idx    (dec_idx)
    );

    // Stage 1: capture decoded fields, index and effective swap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q    <= 1'b0;
            ind1_q  <= 1'b0;
            swap1_q <= 1'b0;
            px1_q   <= '0;
            idx1_q  <= '0;
        end else if (adv) begin
            v1_q    <= s_valid;
            ind1_q  <= dec_idx_en;
            swap1_q <= cfg_fmt[0] ^ cfg_panel_swap;
            px1_q   <= dec_px;
            idx1_q  <= dec_idx;
        end
    end

    pix_clut #(.DEPTH(LUT_DEPTH), .WIDTH(RGB_W)) u_clut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (lut_load),
        .ld_data (lut_data),
        .we      (lut_wr),
        .waddr   (lut_idx),
        .re      (adv),
        .raddr   (idx1_q),
        .rdata   (lut_rd)
    );

    // Stage 2: carry true-colour path alongside the table read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2_q    <= 1'b0;
            ind2_q  <= 1'b0;
            swap2_q <= 1'b0;
            px2_q   <= '0;
        end else if (adv) begin
            v2_q    <= v1_q;
            ind2_q  <= ind1_q;
            swap2_q <= swap1_q;
            px2_q   <= px1_q;
        end
    end

    // Source select between table and decoded fields
    assign sel_px = ind2_q ? rgb_t'(lut_rd) : px2_q;

    pix_rb_order u_order (
        .px   (sel_px),
        .swap (swap2_q),
        .rgb  (m_rgb)
    );

    assign m_valid = v2_q;

endmodule

// File: rtl/pix_unpack_chk.sv
// Module: pix_unpack_chk
// Protocol and field-widening properties for pix_unpack, observed at
// its ports only. Attached to every pix_unpack instance by bind.
module pix_unpack_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  cfg_fmt,
    input logic        s_valid,
    input logic        s_ready,
    input logic        m_valid,
    input logic        m_ready,
    input logic [23:0] m_rgb
);

    // R1: no output beat in the first cycle after reset
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !m_valid);

    // R9: accepted pixel appears once the pipeline advances again
    a_r9_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) ##1 m_ready |=> m_valid);

    // R11: an empty beat reaches the output as a bubble
    a_r11_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_valid && s_ready) ##1 m_ready |=> !m_valid);

    // R10: output frozen while downstream stalls
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_rgb)));

    // R3: 5-6-5 channels widened by repeating their top bits
    a_r3_widen565: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && cfg_fmt[3:1] == 3'd0) ##1 m_ready |=>
        (m_rgb[18:16] == m_rgb[23:21] && m_rgb[9:8] == m_rgb[15:14]
         && m_rgb[2:0] == m_rgb[7:5]));

    // R4: 1-5-5-5 channels widened by repeating their top bits
    a_r4_widen1555: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && cfg_fmt[3:1] == 3'd1) ##1 m_ready |=>
        (m_rgb[18:16] == m_rgb[23:21] && m_rgb[10:8] == m_rgb[15:13]
         && m_rgb[2:0] == m_rgb[7:5]));

endmodule

bind pix_unpack pix_unpack_chk u_chk (.*);

// File: tb/pix_unpack_test.sv
// Bench for pix_unpack: a vector table walked by one loop, then directed
// tests for reset, streaming order, stall, and table write collisions.
module pix_unpack_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  cfg_fmt;
    logic        cfg_panel_swap;
    logic        s_valid;
    logic        s_ready;
    logic [31:0] s_data;
    logic        m_valid;
    logic        m_ready;
    logic [23:0] m_rgb;
    logic        lut_load;
    logic [23:0] lut_data;
    logic        lut_wr;
    logic [7:0]  lut_idx;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pix_unpack uut (.*);

    // Vector: {req[3:0], fmt[3:0], swap, data[31:0], expected[23:0]}
    localparam int NV = 19;
    localparam logic [64:0] VEC [NV] = '{
        {4'd3,  4'b0000, 1'b0, 32'h0000F800, 24'hFF0000}, // R3 red full
        {4'd3,  4'b0000, 1'b0, 32'h000007E0, 24'h00FF00}, // R3 green full
        {4'd3,  4'b0000, 1'b0, 32'h00008410, 24'h848284}, // R3 widening
        {4'd2,  4'b0001, 1'b0, 32'h0000F800, 24'h0000FF}, // R2 order bit
        {4'd6,  4'b0000, 1'b1, 32'h0000001F, 24'hFF0000}, // R6 panel swap
        {4'd6,  4'b0001, 1'b1, 32'h0000001F, 24'h0000FF}, // R6 XOR cancels
        {4'd4,  4'b0010, 1'b0, 32'h00008000, 24'h000000}, // R4 alpha ignored
        {4'd4,  4'b0010, 1'b0, 32'h00007C00, 24'hFF0000}, // R4 red
        {4'd4,  4'b0010, 1'b0, 32'h000003E0, 24'h00FF00}, // R4 green
        {4'd4,  4'b0010, 1'b0, 32'h00000421, 24'h080808}, // R4 widening
        {4'd5,  4'b0100, 1'b0, 32'hAB123456, 24'h123456}, // R5 packed
        {4'd5,  4'b0101, 1'b0, 32'h00123456, 24'h563412}, // R5 packed BGR
        {4'd5,  4'b0110, 1'b0, 32'hFF8090A0, 24'h8090A0}, // R5 unpacked
        {4'd5,  4'b1000, 1'b0, 32'h11223344, 24'h223344}, // R5 alpha
        {4'd6,  4'b1001, 1'b1, 32'h11223344, 24'h223344}, // R6 alpha BGR+swap
        {4'd2,  4'b1100, 1'b0, 32'h00ABCDEF, 24'hABCDEF}, // R2 class 6
        {4'd7,  4'b1010, 1'b0, 32'hFFFFFF05, 24'h05FA39}, // R7 index 5
        {4'd7,  4'b1010, 1'b1, 32'h000000C8, 24'hF437C8}, // R7 index 200 swap
        {4'd7,  4'b1011, 1'b0, 32'h000000FF, 24'hC300FF}  // R7 index 255 BGR
    };

    // Table preload value per entry
    function automatic logic [23:0] lut_init(input int i);
        logic [7:0] b;
        b = 8'(i);
        return {b, ~b, b ^ 8'h3C};
    endfunction

    // Record one comparison
    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Two-step table write, three cycles
    task automatic lut_write(input logic [7:0] idx, input logic [23:0] val);
        @(negedge clk);
        lut_load = 1'b1; lut_data = val;
        @(negedge clk);
        lut_load = 1'b0; lut_wr = 1'b1; lut_idx = idx;
        @(negedge clk);
        lut_wr = 1'b0;
    endtask

    // One isolated pixel; returns at the negedge where output is shown
    task automatic send_one(input logic [3:0] fmt, input logic sw,
                            input logic [31:0] d);
        @(negedge clk);
        cfg_fmt = fmt; cfg_panel_swap = sw; s_valid = 1'b1; s_data = d;
        @(negedge clk);
        s_valid = 1'b0;
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_fmt = '0; cfg_panel_swap = 1'b0;
        s_valid = 1'b0; s_data = '0; m_ready = 1'b1;
        lut_load = 1'b0; lut_data = '0; lut_wr = 1'b0; lut_idx = '0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {31'd0, m_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {31'd0, m_valid}, 32'd0);
        m_ready = 1'b0;
        #1 check("R10 ready follows low", {31'd0, s_ready}, 32'd0);
        m_ready = 1'b1;
        #1 check("R10 ready follows high", {31'd0, s_ready}, 32'd1);

        // R1: holding register cleared: write without load gives zero
        lut_wr = 1'b1; lut_idx = 8'd9;
        @(negedge clk);
        lut_wr = 1'b0;
        send_one(4'b1010, 1'b0, 32'h09);
        check("R1 holding register zero", {8'd0, m_rgb}, 32'h0);

        for (int i = 0; i < 256; i++) lut_write(8'(i), lut_init(i));

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            send_one(VEC[i][60:57], VEC[i][56], VEC[i][55:24]);
            n_checks++;
            if (m_valid !== 1'b1 || m_rgb !== VEC[i][23:0]) begin
                n_fails++;
                $display("FAIL R%0d vector %0d: actual v=%b %h expected %h",
                         VEC[i][64:61], i, m_valid, m_rgb, VEC[i][23:0]);
            end
        end

        // R9: back-to-back stream keeps order and latency
        @(negedge clk);
        cfg_fmt = 4'b0100; cfg_panel_swap = 1'b0;
        s_valid = 1'b1; s_data = 32'h00A1A2A3;
        @(negedge clk);
        check("R9 not yet valid", {31'd0, m_valid}, 32'd0);
        cfg_fmt = 4'b1010; s_data = 32'h00000005;
        @(negedge clk);
        check("R9 first out", {7'd0, m_valid, m_rgb}, {7'd0, 1'b1, 24'hA1A2A3});
        cfg_fmt = 4'b0000; s_data = 32'h0000F800;
        @(negedge clk);
        s_valid = 1'b0;
        check("R9 second out mixed", {7'd0, m_valid, m_rgb}, {7'd0, 1'b1, 24'h05FA39});
        @(negedge clk);
        check("R9 third out", {7'd0, m_valid, m_rgb}, {7'd0, 1'b1, 24'hFF0000});
        @(negedge clk);
        check("R11 bubble after stream", {31'd0, m_valid}, 32'd0);

        // R10 + R8: stall with a table write to the held entry
        @(negedge clk);
        cfg_fmt = 4'b1010; s_valid = 1'b1; s_data = 32'h000000C8;
        @(negedge clk);
        s_valid = 1'b0;
        @(negedge clk);
        check("R10 pre-stall out", {7'd0, m_valid, m_rgb}, {7'd0, 1'b1, 24'hC837F4});
        m_ready = 1'b0;
        s_valid = 1'b1; s_data = 32'h00000005;
        #1 check("R10 s_ready low", {31'd0, s_ready}, 32'd0);
        lut_write(8'hC8, 24'h123ABC);
        @(negedge clk);
        check("R10 held during stall", {7'd0, m_valid, m_rgb}, {7'd0, 1'b1, 24'hC837F4});
        s_valid = 1'b0; m_ready = 1'b1;
        @(negedge clk);
        check("R11 no stalled input taken", {31'd0, m_valid}, 32'd0);
        send_one(4'b1010, 1'b0, 32'h000000C8);
        check("R8 write during stall", {8'd0, m_rgb}, {8'd0, 24'h123ABC});

        // R8: load without write command changes nothing
        @(negedge clk);
        lut_load = 1'b1; lut_data = 24'h777777;
        @(negedge clk);
        lut_load = 1'b0;
        send_one(4'b1010, 1'b0, 32'h00000005);
        check("R8 load alone no write", {8'd0, m_rgb}, {8'd0, 24'h05FA39});

        // R12: write and read of entry 5 on the same edge
        @(negedge clk);
        s_valid = 1'b1; s_data = 32'h00000005;
        @(negedge clk);
        s_valid = 1'b0; lut_wr = 1'b1; lut_idx = 8'd5;
        @(negedge clk);
        lut_wr = 1'b0;
        check("R12 same edge old value", {7'd0, m_valid, m_rgb}, {7'd0, 1'b1, 24'h05FA39});
        send_one(4'b1010, 1'b0, 32'h00000005);
        check("R12 later new value", {8'd0, m_rgb}, {8'd0, 24'h777777});

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    end

endmodule